// File: doc/BRIEF.md
# Phase-Table Time-Based Weighted Round-Robin Arbiter

This block hands out bus grants on a fixed time schedule instead of on demand. A ring of phases (128 by default) is walked at a steady rate, and each phase names one master port that may be granted while that phase is current. The number of phases a port owns sets its share of the bus, so the schedule works as a weighted round robin over time. A port is granted only when it asks for the bus during a phase it owns, and only when that phase is part of a run of at least three consecutive phases assigned to the same port.

The schedule is double buffered. Software fills a shadow table one entry at a time. A load command then copies the shadow table into the working table, one entry per clock. Only the working table drives grant decisions. While the copy runs, a busy flag is raised, no grant is given and the phase position is frozen. The arbiter runs only when its enable input is high and its 3-bit mode select carries the time-based code. At any other time every grant is low and the phase position is parked at zero.

Port number 0 is the bridge master and port number 1 is the peripheral master. Port numbers 2 to 15 are reserved and never produce a grant.

Top module: `phase_wrr_arbiter`

## Requirements
- R1: During reset and in the first clock after it, `gnt` is all zero and `load_busy` is 0. Both tables reset to port number 15 in every phase, so no grant is given until a load has completed.
- R2: While active and not loading, the phase position advances by one every PHASE_CLKS clocks and wraps from the last phase to phase 0. A port owning exactly three phases therefore holds its grant for 3*PHASE_CLKS clocks once every NUM_PHASES*PHASE_CLKS clocks.
- R3: The arbiter is active only when `arb_enable` is 1 and `mode_sel` equals 3'b100. If it is not active in a given clock, `gnt` is all zero in the next clock and the phase position returns to phase 0, so the first active clock uses phase 0.
- R4: A write to the shadow table (`tbl_wr_en`, entry `tbl_wr_idx`, 4-bit port number `tbl_wr_port`) has no effect on `gnt` until a load copies it.
- R5: A `load_go` pulse seen while idle raises `load_busy` in the next clock. `load_busy` then stays high for exactly NUM_PHASES clocks, copying entry k of the shadow table into the working table in the k-th busy clock. A `load_go` pulse seen while `load_busy` is high is ignored.
- R6: While `load_busy` is high, `gnt` is all zero in the next clock and the phase position does not advance.
- R7: `gnt[i]` is 1 in clock t+1 exactly when, in clock t, the arbiter is active and not loading, the current working entry holds port number i, `req[i]` is 1, and the entry lies in a run of at least RUN_MIN (3) equal consecutive entries. The ring is circular, so a run may wrap from the last phase to phase 0.
- R8: A phase whose entry is a reserved port number (2 to 15), or whose run is shorter than RUN_MIN, never produces a grant.
- R9: At most one bit of `gnt` is 1 in any clock.
- R10: A grant falls one clock after its request falls or after the phase position leaves the owning run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_enable | input | 1 | Level-one enable for time-based arbitration |
| mode_sel | input | 3 | Arbitration select; 3'b100 picks the time-based schedule |
| req | input | NUM_PORTS | Per-port bus request |
| tbl_wr_en | input | 1 | Write strobe for the shadow table |
| tbl_wr_idx | input | PH_W | Shadow table entry to write |
| tbl_wr_port | input | 4 | Port number written into the entry |
| load_go | input | 1 | Start a shadow-to-working copy |
| gnt | output | NUM_PORTS | Per-port grant, registered |
| load_busy | output | 1 | High while the copy is in progress |

## Verification
A wrong phase position shows up at the ports within one phase interval as a grant given to the wrong port or at the wrong time, and over a full ring it changes how long each grant lasts and how often it comes back. A fault in the working table or in the run rule shows up within one clock as a grant on a short run, a reserved entry or an entry that was never loaded, which the bench finds by comparing every clock against its own schedule model. A fault in the copy engine changes the length of `load_busy` or leaves a stale entry that appears later as a wrong grant. A fault in enable decoding shows up in the first clock after the enable or mode changes.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    // Width of one phase-table entry (port number)
    localparam int unsigned PORT_W = 4;

    typedef logic [PORT_W-1:0] port_id_t;

    // Reset value of every table entry: a reserved port, never granted
    localparam port_id_t PORT_FILL = port_id_t'((2 ** PORT_W) - 1);

    // Mode select code that picks the time-based schedule
    localparam logic [2:0] SEL_TIMED = 3'b100;

endpackage

// File: rtl/pwa_shadow_table.sv
// Software-facing copy of the phase schedule: one write port, one read port.
module pwa_shadow_table
    import pwa_pkg::*;
#(
    parameter  int unsigned NUM_PHASES = 128,
    localparam int unsigned PH_W       = $clog2(NUM_PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PH_W-1:0] wr_idx,
    input  port_id_t        wr_port,
    input  logic [PH_W-1:0] rd_idx,
    output port_id_t        rd_port
);

    port_id_t tbl_d [NUM_PHASES];
    port_id_t tbl_q [NUM_PHASES];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_port;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: PORT_FILL};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_port = tbl_q[rd_idx];

endmodule

// File: rtl/pwa_loader.sv
// Working table plus the engine that copies the shadow table into it.
module pwa_loader
    import pwa_pkg::*;
#(
    parameter  int unsigned NUM_PHASES = 128,
    localparam int unsigned PH_W       = $clog2(NUM_PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_go,
    input  port_id_t        shadow_port,
    output logic [PH_W-1:0] shadow_idx,
    output logic            busy,
    output port_id_t        work_tbl [NUM_PHASES]
);

    typedef struct packed {
        logic            busy;
        logic [PH_W-1:0] idx;
    } copy_st_t;

    copy_st_t st_d, st_q;
    port_id_t work_d [NUM_PHASES];
    port_id_t work_q [NUM_PHASES];

    always_comb begin
        st_d   = st_q;
        work_d = work_q;
        if (st_q.busy) begin
            work_d[st_q.idx] = shadow_port;
            if (st_q.idx == PH_W'(NUM_PHASES - 1)) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (load_go) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            work_q <= '{default: PORT_FILL};
        end else begin
            st_q   <= st_d;
            work_q <= work_d;
        end
    end

    assign shadow_idx = st_q.idx;
    assign busy       = st_q.busy;
    assign work_tbl   = work_q;

endmodule

// File: rtl/pwa_phase_seq.sv
// Phase position: one step every PHASE_CLKS clocks, circular over the ring.
module pwa_phase_seq #(
    parameter  int unsigned NUM_PHASES = 128,
    parameter  int unsigned PHASE_CLKS = 4,
    localparam int unsigned PH_W       = $clog2(NUM_PHASES),
    localparam int unsigned CNT_W      = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            hold,
    output logic [PH_W-1:0] phase
);

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] tick;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = '0;
        end else if (!hold) begin
            if (st_q.tick == CNT_W'(PHASE_CLKS - 1)) begin
                st_d.tick = '0;
                if (st_q.phase == PH_W'(NUM_PHASES - 1)) begin
                    st_d.phase = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

endmodule

// File: rtl/pwa_grant_qual.sv
// Grant qualification: run-length rule, port decode, request match.
module pwa_grant_qual
    import pwa_pkg::*;
#(
    parameter  int unsigned NUM_PHASES = 128,
    parameter  int unsigned NUM_PORTS  = 2,
    parameter  int unsigned RUN_MIN    = 3,
    localparam int unsigned PH_W       = $clog2(NUM_PHASES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 hold,
    input  logic [PH_W-1:0]      phase,
    input  port_id_t             work_tbl [NUM_PHASES],
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] gnt
);

    port_id_t             cur;
    logic                 run_ok;
    logic [NUM_PORTS-1:0] gnt_d, gnt_q;

    // A run of RUN_MIN equal entries covers the current phase when some
    // window of RUN_MIN entries starting at phase-s (s < RUN_MIN) is uniform.
    always_comb begin
        cur    = work_tbl[phase];
        run_ok = 1'b0;
        for (int unsigned s = 0; s < RUN_MIN; s++) begin
            logic win_ok;
            win_ok = 1'b1;
            for (int unsigned j = 0; j < RUN_MIN; j++) begin
                int unsigned pos;
                pos = (int'(phase) + NUM_PHASES + j - s) % NUM_PHASES;
                if (work_tbl[PH_W'(pos)] != cur) begin
                    win_ok = 1'b0;
                end
            end
            run_ok = run_ok | win_ok;
        end
    end

    always_comb begin
        gnt_d = '0;
        if (active && !hold && run_ok) begin
            for (int unsigned p = 0; p < NUM_PORTS; p++) begin
                if (cur == port_id_t'(p)) begin
                    gnt_d[p] = req[p];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
        end else begin
            gnt_q <= gnt_d;
        end
    end

    assign gnt = gnt_q;

endmodule

// File: rtl/phase_wrr_arbiter.sv
// Time-sliced weighted round-robin arbiter driven by a double-buffered
// phase table.
module phase_wrr_arbiter
    import pwa_pkg::*;
#(
    parameter  int unsigned NUM_PHASES = 128,
    parameter  int unsigned NUM_PORTS  = 2,
    parameter  int unsigned PHASE_CLKS = 4,
    parameter  int unsigned RUN_MIN    = 3,
    localparam int unsigned PH_W       = $clog2(NUM_PHASES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arb_enable,
    input  logic [2:0]           mode_sel,
    input  logic [NUM_PORTS-1:0] req,
    input  logic                 tbl_wr_en,
    input  logic [PH_W-1:0]      tbl_wr_idx,
    input  logic [PORT_W-1:0]    tbl_wr_port,
    input  logic                 load_go,
    output logic [NUM_PORTS-1:0] gnt,
    output logic                 load_busy
);

    logic            active;
    logic [PH_W-1:0] copy_idx;
    port_id_t        copy_port;
    port_id_t        work_tbl [NUM_PHASES];
    logic [PH_W-1:0] phase;

    // Both enable conditions must hold
    assign active = arb_enable && (mode_sel == SEL_TIMED);

    pwa_shadow_table #(
        .NUM_PHASES (NUM_PHASES)
    ) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_port (port_id_t'(tbl_wr_port)),
        .rd_idx  (copy_idx),
        .rd_port (copy_port)
    );

    pwa_loader #(
        .NUM_PHASES (NUM_PHASES)
    ) i_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_go     (load_go),
        .shadow_port (copy_port),
        .shadow_idx  (copy_idx),
        .busy        (load_busy),
        .work_tbl    (work_tbl)
    );

    pwa_phase_seq #(
        .NUM_PHASES (NUM_PHASES),
        .PHASE_CLKS (PHASE_CLKS)
    ) i_phase_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hold   (load_busy),
        .phase  (phase)
    );

    pwa_grant_qual #(
        .NUM_PHASES (NUM_PHASES),
        .NUM_PORTS  (NUM_PORTS),
        .RUN_MIN    (RUN_MIN)
    ) i_grant_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .hold     (load_busy),
        .phase    (phase),
        .work_tbl (work_tbl),
        .req      (req),
        .gnt      (gnt)
    );

endmodule

// File: rtl/pwa_checker.sv
// Port-level properties of the phase-table arbiter.
module pwa_checker #(
    parameter int unsigned NUM_PHASES = 128,
    parameter int unsigned NUM_PORTS  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 arb_enable,
    input logic [2:0]           mode_sel,
    input logic [NUM_PORTS-1:0] req,
    input logic                 load_go,
    input logic [NUM_PORTS-1:0] gnt,
    input logic                 load_busy
);

    localparam int unsigned LEN_W = $clog2(NUM_PHASES + 1) + 1;

    logic [LEN_W-1:0] busy_len;

    // Counts the clocks of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (load_busy) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r3_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_enable && (mode_sel == 3'b100)) |=> (gnt == '0));

    a_r6_loading_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |=> (gnt == '0));

    a_r7_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> ((gnt & ~$past(req)) == '0));

    a_r5_busy_starts_on_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_busy) |-> $past(load_go));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> (busy_len == LEN_W'(NUM_PHASES)));

endmodule

bind phase_wrr_arbiter pwa_checker #(
    .NUM_PHASES (NUM_PHASES),
    .NUM_PORTS  (NUM_PORTS)
) i_pwa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_enable (arb_enable),
    .mode_sel   (mode_sel),
    .req        (req),
    .load_go    (load_go),
    .gnt        (gnt),
    .load_busy  (load_busy)
);

// File: tb/test_phase_wrr_arbiter.sv
`timescale 1ns/1ps
module test_phase_wrr_arbiter;
    import pwa_pkg::*;

    localparam int NP    = 128;
    localparam int NPORT = 2;
    localparam int PCLK  = 4;
    localparam int RMIN  = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             arb_enable;
    logic [2:0]       mode_sel;
    logic [NPORT-1:0] req;
    logic             tbl_wr_en;
    logic [6:0]       tbl_wr_idx;
    logic [3:0]       tbl_wr_port;
    logic             load_go;
    logic [NPORT-1:0] gnt;
    logic             load_busy;

    always #4 clk = ~clk;   // 125 MHz

    phase_wrr_arbiter #(
        .NUM_PHASES (NP),
        .NUM_PORTS  (NPORT),
        .PHASE_CLKS (PCLK),
        .RUN_MIN    (RMIN)
    ) i_phase_wrr_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .arb_enable  (arb_enable),
        .mode_sel    (mode_sel),
        .req         (req),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_idx  (tbl_wr_idx),
        .tbl_wr_port (tbl_wr_port),
        .load_go     (load_go),
        .gnt         (gnt),
        .load_busy   (load_busy)
    );

    int    errors = 0;
    int    checks = 0;
    bit    cmp_on = 1'b0;
    string tag    = "R1";

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- schedule model built from the requirements ----------
    port_id_t         m_sh [NP];
    port_id_t         m_wk [NP];
    int               m_phase, m_tick, m_idx, m_e;
    bit               m_busy, m_act;
    logic [NPORT-1:0] m_gnt, m_ng;

    // Length of the circular run of equal entries through phase p
    function automatic bit run_long(input int p);
        int len;
        len = 1;
        for (int k = 1; k < NP; k++) begin
            if (m_wk[(p + k) % NP] == m_wk[p]) len++;
            else break;
        end
        for (int k = 1; k < NP; k++) begin
            if (m_wk[(p - k + NP) % NP] == m_wk[p]) len++;
            else break;
        end
        return len >= RMIN;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_sh[i] = 4'hF;
                m_wk[i] = 4'hF;
            end
            m_phase = 0; m_tick = 0; m_idx = 0; m_busy = 1'b0; m_gnt = '0;
        end else begin
            m_act = arb_enable && (mode_sel == 3'b100);
            m_ng  = '0;
            if (m_act && !m_busy) begin
                m_e = int'(m_wk[m_phase]);
                if (m_e < NPORT && run_long(m_phase) && req[m_e]) m_ng[m_e] = 1'b1;
            end
            if (!m_act) begin
                m_phase = 0; m_tick = 0;
            end else if (!m_busy) begin
                if (m_tick == PCLK - 1) begin
                    m_tick  = 0;
                    m_phase = (m_phase + 1) % NP;
                end else begin
                    m_tick++;
                end
            end
            if (m_busy) begin
                m_wk[m_idx] = m_sh[m_idx];
                if (m_idx == NP - 1) begin m_busy = 1'b0; m_idx = 0; end
                else m_idx++;
            end else if (load_go) begin
                m_busy = 1'b1; m_idx = 0;
            end
            if (tbl_wr_en) m_sh[tbl_wr_idx] = tbl_wr_port;
            m_gnt = m_ng;
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(gnt == m_gnt, tag, int'(gnt), int'(m_gnt));
            chk(load_busy == m_busy, "R5 busy", int'(load_busy), int'(m_busy));
            chk($countones(gnt) <= 1, "R9 one grant", int'(gnt), 1);
        end
    end

    // ---------------- stimulus helpers ----------------
    port_id_t pat [NP];

    task automatic write_table(input bit rnd_req);
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            tbl_wr_en   = 1'b1;
            tbl_wr_idx  = 7'(i);
            tbl_wr_port = pat[i];
            if (rnd_req) req = NPORT'($urandom);
        end
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic load_and_wait();
        load_go = 1'b1;
        @(negedge clk);
        load_go = 1'b0;
        while (load_busy === 1'b1) @(negedge clk);
    endtask

    int bc, hi, lo, guard, run_len, run_port;

    initial begin
        rst_n = 1'b0; arb_enable = 1'b0; mode_sel = 3'b000; req = '0;
        tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_port = '0; load_go = 1'b0;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk(gnt == '0, "R1 gnt in reset", int'(gnt), 0);
        chk(load_busy == 1'b0, "R1 busy in reset", int'(load_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt == '0, "R1 gnt after reset", int'(gnt), 0);
        chk(load_busy == 1'b0, "R1 busy after reset", int'(load_busy), 0);
        cmp_on = 1'b1;

        // R1: active with all requests high, tables still at reset fill
        tag = "R1 no grant before load";
        arb_enable = 1'b1; mode_sel = 3'b100; req = '1;
        repeat (600) @(negedge clk);

        // Pattern A: directed head, random runs after it
        pat[0] = 4'd0; pat[1] = 4'd0; pat[2] = 4'd0;        // run 3, granted
        pat[3] = 4'd1; pat[4] = 4'd1;                      // run 2, never
        pat[5] = 4'd0;                                     // run 1, never
        pat[6] = 4'd1; pat[7] = 4'd1; pat[8] = 4'd1; pat[9] = 4'd1;
        pat[10] = 4'd7; pat[11] = 4'd7; pat[12] = 4'd7;    // reserved, never
        begin
            int i;
            i = 13;
            while (i < NP) begin
                run_len  = 1 + int'($urandom % 6);
                run_port = int'($urandom % 4);
                for (int k = 0; k < run_len && i < NP; k++) begin
                    pat[i] = port_id_t'(run_port);
                    i++;
                end
            end
        end

        // R4: writes alone do not change grants
        tag = "R4 shadow write has no effect";
        write_table(1'b1);
        repeat (20) @(negedge clk);
        chk(gnt == '0, "R4 no grant after writes", int'(gnt), 0);

        // R5: busy length and ignored second go; R6 during the copy
        tag = "R6 no grant while loading";
        req = '1;
        load_go = 1'b1;
        @(negedge clk);
        load_go = 1'b0;
        chk(load_busy == 1'b1, "R5 busy next clock", int'(load_busy), 1);
        bc = 0;
        while (load_busy === 1'b1 && bc < 400) begin
            bc++;
            load_go = (bc == 60);
            @(negedge clk);
        end
        load_go = 1'b0;
        chk(bc == NP, "R5 busy length", bc, NP);

        // R7 / R8 / R10: random requests over the loaded pattern
        tag = "R7 grant rule";
        for (int c = 0; c < 800; c++) begin
            @(negedge clk);
            if ($urandom % 8 == 0) req = NPORT'($urandom);
        end
        tag = "R8 reserved or short run";
        req = '1;
        repeat (600) @(negedge clk);
        tag = "R10 grant drop";
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            req = NPORT'($urandom);
        end

        // R3: disable by mode, then by enable bit, then re-enable at phase 0
        tag = "R3 enable conditions";
        req = '1;
        mode_sel = 3'b101;
        repeat (40) @(negedge clk);
        chk(gnt == '0, "R3 wrong mode", int'(gnt), 0);
        mode_sel = 3'b100; arb_enable = 1'b0;
        repeat (40) @(negedge clk);
        chk(gnt == '0, "R3 enable low", int'(gnt), 0);
        arb_enable = 1'b1;
        @(negedge clk);
        chk(gnt == 2'b01, "R3 restart at phase 0", int'(gnt), 1);

        // R2: timing table, port 0 owns phases 1..3, port 1 wraps 126,127,0
        tag = "R2 phase timing and wrap";
        for (int i = 0; i < NP; i++) pat[i] = 4'hF;
        pat[1] = 4'd0; pat[2] = 4'd0; pat[3] = 4'd0;
        pat[126] = 4'd1; pat[127] = 4'd1; pat[0] = 4'd1;
        write_table(1'b0);
        load_and_wait();
        arb_enable = 1'b0;
        @(negedge clk);
        arb_enable = 1'b1; req = '1;
        guard = 0;
        while (gnt[0] !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
        hi = 0;
        while (gnt[0] === 1'b1 && hi < 2000) begin @(negedge clk); hi++; end
        lo = 0;
        while (gnt[0] !== 1'b1 && lo < 2000) begin @(negedge clk); lo++; end
        chk(hi == RMIN * PCLK, "R2 grant width", hi, RMIN * PCLK);
        chk(lo == (NP - RMIN) * PCLK, "R2 ring period", lo, (NP - RMIN) * PCLK);
        tag = "R7 wrapped run";
        repeat (1100) @(negedge clk);

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule